// File: doc/BRIEF.md
# External Pin Interrupt Detector

This block watches one asynchronous interrupt pin and turns a qualified transition on it into a sticky request flag. The pin is first brought into the clock domain. It is then gated and adjusted for polarity under a 4-bit control register, and passed to an edge detector that fires on one edge or on both. The same conditioned level drives a wake-up match output and, when enabled, a gate signal for a neighbouring timer.

A separate interrupt-enable bit decides who consumes the flag. With the enable clear, software polls the flag through a skip-test port. A poll that finds the flag set reports a skip and clears the flag in the same cycle. With the enable set, the flag is presented to the CPU as an interrupt request and only an acknowledge clears it. The edge detector looks at the conditioned signal rather than the raw pin, so rewriting the gate or polarity bits can set the flag by itself.

Top module: `extint_detector`

## Requirements
- R1: After reset the control register reads 0000, the enable bit reads 0, and req_flag, irq, poll_skip, wake_match and tmr_ctl are all 0.
- R2: While control bit 3 (pin gate) is 0 the pin has no effect: wake_match stays 0 and no pin activity sets req_flag.
- R3: With bit 3 = 1, bit 2 = 0 and bit 1 = 0, a falling pin transition sets req_flag on the second rising clock edge after the edge that first samples the new pin level; a rising transition does not set it.
- R4: With bit 3 = 1, bit 2 = 1 and bit 1 = 0, a rising pin transition sets req_flag with the same latency as R3; a falling transition does not.
- R5: With bit 3 = 1 and bit 1 = 1, both pin transitions set req_flag with the same latency as R3.
- R6: wake_match is 1 exactly when bit 3 = 1 and the synchronised pin level equals bit 2 (1 = high recognised, 0 = low recognised).
- R7: tmr_ctl is 1 exactly when control bit 0 = 1 and wake_match = 1.
- R8: A control write that makes the conditioned level rise (single-edge) or change (dual-edge) sets req_flag one cycle after the write.
- R9: With the enable bit 0, a poll while req_flag = 1 gives poll_skip = 1 in that cycle and clears req_flag on the next edge; with req_flag = 0 poll_skip is 0.
- R10: With the enable bit 1, irq follows req_flag, polls give poll_skip = 0 and leave the flag, and irq_ack clears it.
- R11: With the enable bit 0, irq stays 0 and irq_ack leaves req_flag unchanged.
- R12: When a detected edge and a clear (poll or acknowledge) fall in the same cycle, req_flag stays 1.
- R13: cfg_rdata and ie_rdata return the last values written through cfg_we and ie_we.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 1 | Asynchronous external interrupt pin |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 4 | Control write data: bit3 gate, bit2 polarity, bit1 dual edge, bit0 timer link |
| ie_we | input | 1 | Enable bit write strobe |
| ie_wdata | input | 1 | Enable bit write data |
| poll_req | input | 1 | Skip-test poll of the request flag |
| irq_ack | input | 1 | CPU acknowledge of the interrupt |
| cfg_rdata | output | 4 | Control register contents |
| ie_rdata | output | 1 | Enable bit contents |
| req_flag | output | 1 | Sticky request flag |
| irq | output | 1 | Interrupt request to the CPU |
| poll_skip | output | 1 | Skip result of the current poll |
| wake_match | output | 1 | Pin at the recognised level |
| tmr_ctl | output | 1 | Timer gate from the pin |

## Verification
The properties assume that poll_req and irq_ack are single-cycle decisions of the CPU taken on the flag value of the same cycle, and that the pin may move on any cycle, since only the synchronised copy reaches the detector. The stimulus drives every input at the falling clock edge, so each one is stable across the sampling edge. Pin, poll and acknowledge activity is drawn at random at rates high enough that edges, polls and acknowledges coincide often. Control and enable writes are drawn more rarely, so that each configuration stays in place long enough for pin transitions to reach the flag.

// File: rtl/extint_pkg.sv
`timescale 1ns/1ps
package extint_pkg;
  localparam int CFG_W = 4;

  // Field order is the software-visible bit order (MSB first).
  typedef struct packed {
    logic pin_en;     // bit 3: pass the pin on
    logic lvl_high;   // bit 2: rising / high level when 1
    logic dual_edge;  // bit 1: detect both edges
    logic tmr_link;   // bit 0: pin drives timer gate
  } xcfg_t;

  localparam xcfg_t XCFG_RST = '0;
endpackage

// File: rtl/extint_rst_sync.sv
`timescale 1ns/1ps
module extint_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/extint_sync.sv
`timescale 1ns/1ps
module extint_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] stg_q;
  logic [STAGES-1:0] stg_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb stg_d = d_async;
    end else begin : g_many
      always_comb stg_d = {stg_q[STAGES-2:0], d_async};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign q_sync = stg_q[STAGES-1];
endmodule

// File: rtl/extint_cond.sv
`timescale 1ns/1ps
module extint_cond
  import extint_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  pin_s,
  input  xcfg_t cfg,
  output logic  active,
  output logic  edge_hit
);
  logic lvl_q;
  logic lvl_d;
  logic cur;

  // Gated, polarity-adjusted level: 1 means "recognised level present".
  always_comb begin
    cur   = cfg.pin_en & ~(pin_s ^ cfg.lvl_high);
    lvl_d = cur;
    if (cfg.dual_edge) edge_hit = cur ^ lvl_q;
    else               edge_hit = cur & ~lvl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl_d;
  end

  assign active = cur;
endmodule

// File: rtl/extint_flag.sv
`timescale 1ns/1ps
module extint_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic edge_hit,
  input  logic ie,
  input  logic poll_req,
  input  logic irq_ack,
  output logic flag,
  output logic skip,
  output logic irq
);
  logic flag_q;
  logic flag_d;
  logic clr;

  always_comb begin
    skip   = poll_req & ~ie & flag_q;
    clr    = skip | (irq_ack & ie);
    flag_d = flag_q;
    if (clr)      flag_d = 1'b0;
    if (edge_hit) flag_d = 1'b1;   // a new edge wins over a clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;
  assign irq  = flag_q & ie;
endmodule

// File: rtl/extint_detector.sv
`timescale 1ns/1ps
module extint_detector
  import extint_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_in,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             ie_we,
  input  logic             ie_wdata,
  input  logic             poll_req,
  input  logic             irq_ack,
  output logic [CFG_W-1:0] cfg_rdata,
  output logic             ie_rdata,
  output logic             req_flag,
  output logic             irq,
  output logic             poll_skip,
  output logic             wake_match,
  output logic             tmr_ctl
);
  logic  rst_sync_n;
  logic  pin_s;
  logic  edge_hit;
  logic  active;
  xcfg_t cfg_q, cfg_d;
  logic  ie_q, ie_d;

  extint_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .arst_n(rst_n), .rst_n_o(rst_sync_n)
  );

  extint_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_sync_n), .d_async(pin_in), .q_sync(pin_s)
  );

  // Register next state with explicit write enables.
  always_comb begin
    cfg_d = cfg_q;
    ie_d  = ie_q;
    if (cfg_we) cfg_d = xcfg_t'(cfg_wdata);
    if (ie_we)  ie_d  = ie_wdata;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cfg_q <= XCFG_RST;
      ie_q  <= 1'b0;
    end else begin
      cfg_q <= cfg_d;
      ie_q  <= ie_d;
    end
  end

  extint_cond u_cond (
    .clk(clk), .rst_n(rst_sync_n), .pin_s(pin_s), .cfg(cfg_q),
    .active(active), .edge_hit(edge_hit)
  );

  extint_flag u_flag (
    .clk(clk), .rst_n(rst_sync_n), .edge_hit(edge_hit), .ie(ie_q),
    .poll_req(poll_req), .irq_ack(irq_ack),
    .flag(req_flag), .skip(poll_skip), .irq(irq)
  );

  assign cfg_rdata  = cfg_q;
  assign ie_rdata   = ie_q;
  assign wake_match = active;
  assign tmr_ctl    = active & cfg_q.tmr_link;
endmodule

// File: rtl/extint_detector_chk.sv
`timescale 1ns/1ps
module extint_detector_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] cfg,
  input logic       ie,
  input logic       req_flag,
  input logic       poll_req,
  input logic       poll_skip,
  input logic       irq_ack,
  input logic       edge_hit
);
  // R3
  flag_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_flag) |-> $past(edge_hit));

  // R12
  edge_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_hit |=> req_flag);

  // R9
  skip_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    poll_skip |-> (req_flag && !ie));

  // R9
  poll_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_skip && !edge_hit) |=> !req_flag);

  // R10
  poll_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ie && !irq_ack && req_flag) |=> req_flag);

  // R11
  ack_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ie && irq_ack && !poll_req && req_flag) |=> req_flag);

  // R2
  gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg[3] && $past(!cfg[3])) |-> !edge_hit);
endmodule

bind extint_detector extint_detector_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .cfg(cfg_rdata), .ie(ie_rdata),
  .req_flag(req_flag), .poll_req(poll_req), .poll_skip(poll_skip),
  .irq_ack(irq_ack), .edge_hit(edge_hit)
);

// File: tb/sim_extint_detector.sv
`timescale 1ns/1ps
module sim_extint_detector;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       pin_in, cfg_we, ie_we, ie_wdata, poll_req, irq_ack;
  logic [3:0] cfg_wdata;
  logic [3:0] cfg_rdata;
  logic       ie_rdata, req_flag, irq, poll_skip, wake_match, tmr_ctl;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // bench model state
  logic       m_s1, m_s2, m_cq, m_flag, m_ie;
  logic [3:0] m_cfg;

  always #2.5 clk = ~clk;

  extint_detector u0 (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .ie_we(ie_we), .ie_wdata(ie_wdata),
    .poll_req(poll_req), .irq_ack(irq_ack), .cfg_rdata(cfg_rdata),
    .ie_rdata(ie_rdata), .req_flag(req_flag), .irq(irq),
    .poll_skip(poll_skip), .wake_match(wake_match), .tmr_ctl(tmr_ctl)
  );

  task automatic chk(input string req, input string what,
                     input logic [3:0] got, input logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h at %0t", req, what, got, exp, $time);
    end
  endtask

  function automatic logic f_level(input logic [3:0] c, input logic s);
    return c[3] & (s == c[2]);
  endfunction

  function automatic logic f_edge(input logic [3:0] c, input logic lv, input logic prev);
    return c[1] ? (lv ^ prev) : (lv & ~prev);
  endfunction

  task automatic step(input logic p, input logic cw, input logic [3:0] cd,
                      input logic iw, input logic id, input logic pr,
                      input logic ak, input string ftag);
    logic lv, eg, sk, nf;
    @(negedge clk);
    pin_in = p; cfg_we = cw; cfg_wdata = cd; ie_we = iw; ie_wdata = id;
    poll_req = pr; irq_ack = ak;
    #1;
    lv = f_level(m_cfg, m_s2);
    eg = f_edge(m_cfg, lv, m_cq);
    sk = pr & ~m_ie & m_flag;
    chk(ftag,  "req_flag",   {3'b0, req_flag},   {3'b0, m_flag});
    chk("R9",  "poll_skip",  {3'b0, poll_skip},  {3'b0, sk});
    chk("R10 R11", "irq",    {3'b0, irq},        {3'b0, m_flag & m_ie});
    chk("R6",  "wake_match", {3'b0, wake_match}, {3'b0, lv});
    chk("R7",  "tmr_ctl",    {3'b0, tmr_ctl},    {3'b0, lv & m_cfg[0]});
    chk("R13", "cfg_rdata",  cfg_rdata,          m_cfg);
    chk("R13", "ie_rdata",   {3'b0, ie_rdata},   {3'b0, m_ie});
    nf = eg | (m_flag & ~(sk | (ak & m_ie)));
    @(posedge clk);
    m_flag = nf;
    m_cq   = lv;
    m_s2   = m_s1;
    m_s1   = p;
    if (cw) m_cfg = cd;
    if (iw) m_ie  = id;
  endtask

  // shorthand: pin only
  task automatic pin_steps(input logic p, input int n, input string t);
    for (int i = 0; i < n; i++) step(p, 0, 4'h0, 0, 0, 0, 0, t);
  endtask

  task automatic wr_cfg(input logic p, input logic [3:0] c, input string t);
    step(p, 1, c, 0, 0, 0, 0, t);
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int unsigned seed = 32'h5eed_0042;
    logic rp;
    void'($urandom(seed));
    rst_n = 1'b0; pin_in = 0; cfg_we = 0; cfg_wdata = 0; ie_we = 0;
    ie_wdata = 0; poll_req = 0; irq_ack = 0;
    m_s1 = 0; m_s2 = 0; m_cq = 0; m_flag = 0; m_ie = 0; m_cfg = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1", "cfg_rdata", cfg_rdata, 4'h0);
    chk("R1", "ie/flag/irq/skip/wake/tmr",
        {ie_rdata, req_flag, irq, poll_skip | wake_match | tmr_ctl}, 4'h0);
    @(negedge clk); rst_n = 1'b1;
    repeat (5) @(posedge clk);

    // R2: gate off, pin toggles ignored
    for (int i = 0; i < 4; i++) begin
      pin_steps(1'b1, 3, "R2");
      pin_steps(1'b0, 3, "R2");
    end
    // R8: enable gate with low-level polarity while pin low
    wr_cfg(1'b0, 4'b1000, "R8");
    pin_steps(1'b0, 2, "R8");
    // R9: poll consumes
    step(0, 0, 0, 0, 0, 1, 0, "R9");
    step(0, 0, 0, 0, 0, 1, 0, "R9");
    // R3: falling single edge, rising ignored
    pin_steps(1'b1, 4, "R3");
    pin_steps(1'b0, 4, "R3");
    step(0, 0, 0, 0, 0, 1, 0, "R3");
    pin_steps(1'b1, 4, "R3");
    // R4: rising polarity (pin high now: write may set flag per R8)
    wr_cfg(1'b1, 4'b1100, "R8");
    step(1, 0, 0, 0, 0, 1, 0, "R4");
    pin_steps(1'b0, 4, "R4");
    pin_steps(1'b1, 4, "R4");
    step(1, 0, 0, 0, 0, 1, 0, "R4");
    // R5: dual edge plus timer link
    wr_cfg(1'b1, 4'b1111, "R5");
    step(1, 0, 0, 0, 0, 1, 0, "R5");
    pin_steps(1'b0, 4, "R5");
    step(0, 0, 0, 0, 0, 1, 0, "R5");
    pin_steps(1'b1, 4, "R5");
    // R11: ack ignored with enable clear
    step(1, 0, 0, 0, 0, 0, 1, "R11");
    step(1, 0, 0, 0, 0, 0, 1, "R11");
    // R12: edge and poll in the same cycle (edge visible two steps after pin move)
    step(0, 0, 0, 0, 0, 0, 0, "R12");
    step(0, 0, 0, 0, 0, 0, 0, "R12");
    step(0, 0, 0, 0, 0, 1, 0, "R12");
    step(0, 0, 0, 0, 0, 0, 0, "R12");
    // R10: interrupt mode, poll ignored, ack clears
    step(0, 0, 0, 1, 1, 0, 0, "R10");
    step(0, 0, 0, 0, 0, 1, 0, "R10");
    step(0, 0, 0, 0, 0, 1, 0, "R10");
    step(0, 0, 0, 0, 0, 0, 1, "R10");
    step(0, 0, 0, 0, 0, 0, 0, "R10");

    // constrained random
    rp = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      logic cw, iw;
      if (($urandom % 5) == 0) rp = ~rp;
      cw = (($urandom % 24) == 0);
      iw = (($urandom % 40) == 0);
      step(rp, cw, 4'($urandom), iw, 1'($urandom), (($urandom % 4) == 0),
           (($urandom % 4) == 0), "R3 R4 R5 R8 R12");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule